// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter. It drives a trial code to an external DAC and analog input multiplexer. It reads back one comparator bit per step. It groups conversions into sequences of four and places the four results in four result registers. All timing runs on the system bus clock.

A single control write sets three things: the channel number, whether the four conversions use one channel or a group of four neighbouring channels, and whether the sequence runs once or repeats. The write also starts the sequence. A power-up enable must be high before any conversion runs. A completion flag rises only when the fourth result of a sequence has been stored.

Top module: `sar_seq_top`

## Requirements
- R1: After synchronous reset, `done_flag`, `busy`, `dac_code` and all four result slots are zero.
- R2: While `pwr_en` is low, no conversion runs. A control write only stores the settings. If `pwr_en` drops during a run, `busy` falls on the next clock and no result slot changes. Raising `pwr_en` again does not start a sequence by itself.
- R3: Each conversion has two phases. First comes a sample phase with `dac_code` at zero. Then come eight one-clock steps, starting at the most significant bit. The first trial code is 0x80. Each step keeps its bit when `cmp_in` is 1. The stored result is the largest code the comparator accepted.
- R4: A conversion lasts 32 clocks, made of 24 sample clocks and 8 steps. Slot k (k = 0..3, at `res_flat[8k+7:8k]`) is written on the clock edge 32*(k+1) cycles after the edge that accepted the control write. Before that edge, slot k keeps its old value.
- R5: Single-channel mode (`ctl_wdata[4]` = 0): all four conversions use channel `ctl_wdata[3:0]` on `chan_sel`.
- R6: Multi-channel mode (`ctl_wdata[4]` = 1): conversion k uses channel {`ctl_wdata[3:2]`, k}, in ascending order. `ctl_wdata[1:0]` are ignored.
- R7: `done_flag` rises on the same edge that stores slot 3, and not before. In one-shot mode (`ctl_wdata[5]` = 0), `busy` falls on that same edge.
- R8: In continuous mode (`ctl_wdata[5]` = 1), a new sequence starts right after slot 3. `done_flag` stays set, `busy` stays high, and the result slots are overwritten as the later conversions finish.
- R9: A control write while powered aborts any running sequence. It clears `done_flag` on the next clock, restarts at slot 0, and holds `busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Converter power-up enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | [3:0] channel, [4] multi-channel, [5] continuous |
| cmp_in | input | 1 | Comparator: 1 when the selected input is at or above `dac_code` |
| dac_code | output | 8 | Trial code to the DAC |
| chan_sel | output | 4 | Analog multiplexer channel |
| busy | output | 1 | Sequence in progress |
| done_flag | output | 1 | Four results of a sequence are available |
| res_flat | output | 32 | Four 8-bit result slots, slot k at bits 8k+7:8k |

## Verification
Every result is due on a fixed edge counted from the edge that accepted the control write. Slot k lands 32*(k+1) edges later, and the flag rises with slot 3. The trial code is 0 at 23 edges into each conversion and 0x80 at 24.

The bench drives inputs on falling edges. It counts falling edges from the write and samples each slot one edge before its due point and again at it. The flag is sampled at edges 127 and 128. Channel selection is sampled mid-conversion. In continuous mode the analog values change exactly at a sequence boundary, so the bench can check the second sequence's overwrite.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Sequencer state
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // Control word field offsets relative to the channel width
  function automatic int multi_bit(input int ch_w);
    return ch_w;
  endfunction

  function automatic int cont_bit(input int ch_w);
    return ch_w + 1;
  endfunction

endpackage

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES_W    = 8,
  parameter int CONV_CYC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             conv_done,
  output logic [RES_W-1:0] conv_result
);
  localparam int SAMPLE_CYC = CONV_CYC - RES_W;
  localparam int CNT_W      = $clog2(CONV_CYC);

  logic [CNT_W-1:0] cnt;
  logic [RES_W-1:0] sar;
  logic [RES_W-1:0] sar_next;
  logic             last_step;
  int               bit_idx;

  assign last_step = (cnt == CNT_W'(CONV_CYC - 1));
  assign bit_idx   = RES_W - 1 - (int'(cnt) - SAMPLE_CYC);

  // Decide the current bit and arm the next lower one
  always_comb begin
    sar_next = sar;
    for (int b = 0; b < RES_W; b++) begin
      if (b == bit_idx)     sar_next[b] = cmp_in;
      if (b + 1 == bit_idx) sar_next[b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= '0;
      sar <= '0;
    end else begin
      cnt <= last_step ? '0 : cnt + CNT_W'(1);
      if (cnt == CNT_W'(SAMPLE_CYC - 1))
        sar <= {1'b1, {(RES_W-1){1'b0}}};
      else if (int'(cnt) >= SAMPLE_CYC)
        sar <= last_step ? '0 : sar_next;
    end
  end

  assign dac_code    = sar;
  assign conv_done   = run && !restart && last_step;
  assign conv_result = sar_next;

  // R3: the first trial code of every conversion is the MSB alone
  p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && cnt == CNT_W'(SAMPLE_CYC)) |-> (dac_code == {1'b1, {(RES_W-1){1'b0}}}));

  // R3: the trial code is zero throughout the sample phase
  p_sample_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) < SAMPLE_CYC) |-> (dac_code == '0));

endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int RES_W = 8,
  parameter int SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic [RES_W-1:0]         wr_data,
  output logic [SLOTS*RES_W-1:0]   res_flat
);
  localparam int SLOT_W = $clog2(SLOTS);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [RES_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_en && wr_slot == SLOT_W'(s))
        q <= wr_data;
    end
    assign res_flat[s*RES_W +: RES_W] = q;
  end

  // R4: conversions are at least two cycles apart, so writes never repeat back to back
  p_one_write_per_conv_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwr_en,
  input  logic                     ctl_wr,
  input  logic [CH_W+1:0]          ctl_wdata,
  input  logic                     conv_done,
  output logic                     core_run,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic [CH_W-1:0]          chan_sel,
  output logic                     busy,
  output logic                     done_flag
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int MB     = multi_bit(CH_W);
  localparam int CB     = cont_bit(CH_W);

  seq_state_t      state;
  logic [CH_W-1:0] cfg_chan;
  logic            cfg_multi;
  logic            cfg_cont;
  logic            last_slot;

  assign last_slot = (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      cfg_chan  <= '0;
      cfg_multi <= 1'b0;
      cfg_cont  <= 1'b0;
      slot      <= '0;
      done_flag <= 1'b0;
    end else if (ctl_wr) begin
      cfg_chan  <= ctl_wdata[CH_W-1:0];
      cfg_multi <= ctl_wdata[MB];
      cfg_cont  <= ctl_wdata[CB];
      slot      <= '0;
      done_flag <= 1'b0;
      state     <= pwr_en ? SEQ_RUN : SEQ_IDLE;
    end else if (!pwr_en) begin
      state <= SEQ_IDLE;
      slot  <= '0;
    end else if (state == SEQ_RUN && conv_done) begin
      if (last_slot) begin
        done_flag <= 1'b1;
        slot      <= '0;
        if (!cfg_cont) state <= SEQ_IDLE;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end

  assign core_run = (state == SEQ_RUN) && pwr_en;
  assign busy     = (state == SEQ_RUN);
  assign chan_sel = cfg_multi ? {cfg_chan[CH_W-1:SLOT_W], slot} : cfg_chan;

  // R2: losing power ends any run on the next edge
  p_no_run_unpowered_r2: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> !busy);

  // R7: the flag rises only with the final conversion of a sequence
  p_flag_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(conv_done && last_slot));

  // R8: in continuous mode the flag is held until the next control write
  p_cont_flag_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (done_flag && cfg_cont && !ctl_wr) |=> done_flag);

  // R9: a control write clears the flag
  p_wr_clears_flag_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !done_flag);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES_W    = 8,
  parameter int SLOTS    = 4,
  parameter int CH_W     = 4,
  parameter int CONV_CYC = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_en,
  input  logic                   ctl_wr,
  input  logic [CH_W+1:0]        ctl_wdata,
  input  logic                   cmp_in,
  output logic [RES_W-1:0]       dac_code,
  output logic [CH_W-1:0]        chan_sel,
  output logic                   busy,
  output logic                   done_flag,
  output logic [SLOTS*RES_W-1:0] res_flat
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              core_run;
  logic              conv_done;
  logic [RES_W-1:0]  conv_result;
  logic [SLOT_W-1:0] slot;

  adc_seq_ctrl #(.CH_W(CH_W), .SLOTS(SLOTS)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_en    (pwr_en),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .conv_done (conv_done),
    .core_run  (core_run),
    .slot      (slot),
    .chan_sel  (chan_sel),
    .busy      (busy),
    .done_flag (done_flag)
  );

  sar_core #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) core_i (
    .clk         (clk),
    .rst         (rst),
    .run         (core_run),
    .restart     (ctl_wr),
    .cmp_in      (cmp_in),
    .dac_code    (dac_code),
    .conv_done   (conv_done),
    .conv_result (conv_result)
  );

  result_bank #(.RES_W(RES_W), .SLOTS(SLOTS)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (conv_done),
    .wr_slot  (slot),
    .wr_data  (conv_result),
    .res_flat (res_flat)
  );

endmodule

// File: tb/sar_seq_top_tb.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_en = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic        cmp_in;
  logic [7:0]  dac_code;
  logic [3:0]  chan_sel;
  logic        busy;
  logic        done_flag;
  logic [31:0] res_flat;

  logic [7:0] ana [16];
  logic [7:0] exp_res [4];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Ideal comparator and input multiplexer model
  assign cmp_in = (ana[chan_sel] >= dac_code);

  sar_seq_top dut_i (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel), .busy(busy),
    .done_flag(done_flag), .res_flat(res_flat)
  );

  function automatic logic [7:0] slot_val(input int k);
    return res_flat[8*k +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_ctl(input logic [5:0] d);
    ctl_wdata = d;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic fill_ana(input int t);
    for (int i = 0; i < 16; i++) begin
      if (t == 0)      ana[i] = 8'd0;
      else if (t == 1) ana[i] = 8'd255;
      else             ana[i] = 8'((i * 29 + t * 71 + 5) & 255);
    end
  endtask

  // Run one full sequence from a control write, checking on the due edges
  task automatic run_seq(input logic [3:0] ch, input bit mul, input bit cont);
    write_ctl({cont, mul, ch});
    chk(done_flag == 1'b0, "R9 flag cleared by write", int'(done_flag), 0);
    chk(busy == 1'b1, "R9 busy after write", int'(busy), 1);
    for (int c = 1; c <= 128; c++) begin
      int k;
      int ech;
      @(negedge clk);
      k = (c - 1) / 32;
      ech = mul ? ((int'(ch) & 12) | k) : int'(ch);
      if (c % 32 == 16)
        chk(int'(chan_sel) == ech, mul ? "R6 group channel" : "R5 single channel", int'(chan_sel), ech);
      if (c % 32 == 23)
        chk(dac_code == 8'd0, "R3 sample code", int'(dac_code), 0);
      if (c % 32 == 24)
        chk(dac_code == 8'h80, "R3 msb trial", int'(dac_code), 128);
      if (c % 32 == 31)
        chk(slot_val(k) == exp_res[k], "R4 slot not early", int'(slot_val(k)), int'(exp_res[k]));
      if (c % 32 == 0) begin
        exp_res[k] = ana[ech];
        chk(slot_val(k) == exp_res[k], "R3 R4 result", int'(slot_val(k)), int'(exp_res[k]));
      end
      if (c == 127)
        chk(done_flag == 1'b0, "R7 flag not early", int'(done_flag), 0);
      if (c == 128) begin
        chk(done_flag == 1'b1, "R7 flag set", int'(done_flag), 1);
        chk(busy == cont, cont ? "R8 busy kept" : "R7 busy drops", int'(busy), int'(cont));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    fill_ana(0);
    for (int k = 0; k < 4; k++) exp_res[k] = 8'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done_flag == 1'b0, "R1 flag", int'(done_flag), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(dac_code == 8'd0, "R1 dac", int'(dac_code), 0);
    chk(res_flat == 32'd0, "R1 results", int'(res_flat), 0);

    // R2 write while unpowered does nothing
    fill_ana(5);
    write_ctl(6'b010011);
    repeat (150) @(negedge clk);
    chk(busy == 1'b0, "R2 no start unpowered", int'(busy), 0);
    chk(res_flat == 32'd0, "R2 results untouched", int'(res_flat), 0);
    chk(done_flag == 1'b0, "R2 flag untouched", int'(done_flag), 0);
    pwr_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(busy == 1'b0, "R2 no auto start", int'(busy), 0);

    // Single-channel sweep over every channel
    for (int t = 0; t < 8; t++) begin
      fill_ana(t);
      for (int ch = 0; ch < 16; ch++) run_seq(4'(ch), 1'b0, 1'b0);
    end

    // Multi-channel sweep over every group with varying ignored low bits
    for (int t = 0; t < 8; t++) begin
      fill_ana(t + 8);
      for (int g = 0; g < 4; g++) run_seq(4'(g * 4 + (t % 4)), 1'b1, 1'b0);
    end

    // R8 continuous mode: second sequence overwrites with new inputs
    fill_ana(20);
    run_seq(4'd5, 1'b1, 1'b1);
    fill_ana(21);
    for (int c = 129; c <= 256; c++) begin
      @(negedge clk);
      if (c == 160 || c == 255)
        chk(done_flag == 1'b1, "R8 flag held", int'(done_flag), 1);
      if (c == 200)
        chk(busy == 1'b1, "R8 still busy", int'(busy), 1);
    end
    for (int k = 0; k < 4; k++) begin
      exp_res[k] = ana[4 + k];
      chk(slot_val(k) == exp_res[k], "R8 overwritten", int'(slot_val(k)), int'(exp_res[k]));
    end

    // R9 abort mid-conversion with a new one-shot configuration
    repeat (40) @(negedge clk);
    run_seq(4'd9, 1'b0, 1'b0);

    // R2 power loss during a run
    fill_ana(30);
    write_ctl(6'b100000);
    repeat (10) @(negedge clk);
    pwr_en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2 abort on power loss", int'(busy), 0);
    repeat (200) @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk(slot_val(k) == exp_res[k], "R2 results kept", int'(slot_val(k)), int'(exp_res[k]));
    pwr_en = 1'b1;
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R2 stays idle after power returns", int'(busy), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule